// File: doc/BRIEF.md
# Power Partition Gate Controller

This block switches power to up to 32 independent power partitions and holds each partition's output isolation clamp. Software reaches it through a simple register read/write port at three offsets. Writing a command word to the toggle offset flips the power request of one partition. Writing a one-hot mask to the clamp-release offset removes the isolation clamp of a partition that is powered. Reading the status offset returns the settled power state of all partitions.

Only one toggle can be in flight at a time. After a toggle, the power-enable output changes at once. The matching status bit follows only after a programmable number of clock cycles, which stands in for the settling time of the switch. A toggle that arrives during this window is discarded and raises a sticky error flag. Clamps come out of reset asserted. The block re-applies a clamp itself whenever its partition is switched off. For two partitions chosen by parameter, the release bits are exchanged.

Top module: `pwr_part_gate_ctrl`

## Requirements
- R1: After reset, every bit of `pwr_en_o` is 0, every bit of `clamp_o` is 1, `err_o` is 0 and the status register reads 0.
- R2: A write to offset 0x30 whose bit 8 is 1 inverts `pwr_en_o[n]` at the next clock edge, where n is taken from write data bits [4:0]. The same write with bit 8 at 0 changes nothing.
- R3: Status bit n (read at offset 0x38, bit n, 1 = powered) takes the new value of `pwr_en_o[n]` exactly SETTLE clock edges after the edge that accepted the toggle, and changes at no other time.
- R4: A toggle whose accepting edge falls within the SETTLE edges after an accepted toggle, up to and including the edge that updates status, is discarded. That discarded toggle sets `err_o`, which then stays 1 until reset.
- R5: A write to offset 0x34 with bit n set releases the clamp of partition n (`clamp_o[n]` goes to 0 at the next edge) only if `pwr_en_o[n]` is 1. The write has no effect on an unpowered partition.
- R6: For partitions SWAP_A (default 2) and SWAP_B (default 3), the clamp-release bits are exchanged. Bit SWAP_B releases partition SWAP_A, and bit SWAP_A releases partition SWAP_B.
- R7: When a toggle turns `pwr_en_o[n]` off, `clamp_o[n]` returns to 1 on the same clock edge.
- R8: `rdata_o` is zero unless a read (`req_i`=1, `we_i`=0) targets offset 0x38. Reads at 0x30, 0x34 and any other offset return zero.
- R9: Writes to any offset other than 0x30 and 0x34 change no output and no status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 8 | Byte offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational |
| pwr_en_o | output | 32 | Per-partition power enable |
| clamp_o | output | 32 | Per-partition isolation clamp, 1 = clamped |
| err_o | output | 1 | Sticky flag for a discarded toggle |

## Verification
Several properties are checked by assertions on every cycle. A clamp never drops while its partition is unpowered. A power enable moves only on an accepted toggle, and a status bit moves only on a settle completion. No toggle is accepted while one is settling, and the error flag never clears once it is set. Other behaviours can be shown only by the bench's scenarios, which compare against a behavioural model on every clock. These include the exact edge at which status follows, the drop window boundary one edge before and after completion, the exchanged release bits, and the zero read-back at unmapped offsets.

// File: rtl/pgc_pkg.sv
package pgc_pkg;
  localparam logic [7:0] OFS_TOGGLE = 8'h30;
  localparam logic [7:0] OFS_CLAMP  = 8'h34;
  localparam logic [7:0] OFS_STATUS = 8'h38;
  localparam int         START_BIT  = 8;

  // write-data bit that releases partition n
  function automatic int clamp_src_bit(int n, int a, int b);
    if (n == a) return b;
    if (n == b) return a;
    return n;
  endfunction
endpackage

// File: rtl/pgc_bus_decode.sv
module pgc_bus_decode import pgc_pkg::*; #(
  parameter int NP     = 32,
  parameter int AW     = 8,
  parameter int DW     = 32,
  parameter int SWAP_A = 2,
  parameter int SWAP_B = 3,
  localparam int IDX_W = (NP > 1) ? $clog2(NP) : 1
) (
  input  logic             req_i,
  input  logic             we_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic             busy_i,
  input  logic [NP-1:0]    status_i,
  output logic             tog_ok_o,
  output logic             tog_drop_o,
  output logic [IDX_W-1:0] tog_idx_o,
  output logic [NP-1:0]    rel_o,
  output logic [DW-1:0]    rdata_o
);
  logic wr, tog_cmd, clamp_wr, rd_stat;

  assign wr       = req_i && we_i;
  assign tog_cmd  = wr && (addr_i == AW'(OFS_TOGGLE)) && wdata_i[START_BIT];
  assign clamp_wr = wr && (addr_i == AW'(OFS_CLAMP));
  assign rd_stat  = req_i && !we_i && (addr_i == AW'(OFS_STATUS));

  assign tog_ok_o   = tog_cmd && !busy_i;
  assign tog_drop_o = tog_cmd && busy_i;
  assign tog_idx_o  = wdata_i[IDX_W-1:0];

  for (genvar n = 0; n < NP; n++) begin : g_rel
    localparam int SRC = clamp_src_bit(n, SWAP_A, SWAP_B);
    assign rel_o[n] = clamp_wr && wdata_i[SRC];
  end

  always_comb begin
    rdata_o = '0;
    if (rd_stat) rdata_o[NP-1:0] = status_i;
  end
endmodule

// File: rtl/pgc_settle.sv
module pgc_settle #(
  parameter int SETTLE = 25,
  localparam int CW = (SETTLE > 1) ? $clog2(SETTLE) : 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o,
  output logic done_o
);
  logic [CW-1:0] cnt_q;
  logic          busy_q;

  assign busy_o = busy_q;
  assign done_o = busy_q && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      cnt_q  <= CW'(SETTLE - 1);
    end else if (done_o) begin
      busy_q <= 1'b0;
    end else if (busy_q) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assert_no_restart_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !busy_q);
  assert_done_ends_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_q);
endmodule

// File: rtl/pgc_partition.sv
module pgc_partition (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tog_i,
  input  logic done_i,
  input  logic rel_i,
  output logic pwr_en_o,
  output logic status_o,
  output logic clamp_o
);
  logic pwr_en_q, status_q, clamp_q;

  assign pwr_en_o = pwr_en_q;
  assign status_o = status_q;
  assign clamp_o  = clamp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pwr_en_q <= 1'b0;
      status_q <= 1'b0;
      clamp_q  <= 1'b1;
    end else begin
      if (tog_i) begin
        pwr_en_q <= !pwr_en_q;
        if (pwr_en_q) clamp_q <= 1'b1;   // switching off: re-clamp
      end else if (rel_i && pwr_en_q) begin
        clamp_q <= 1'b0;
      end
      if (done_i) status_q <= pwr_en_q;
    end
  end

  assert_clamp_while_off_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_en_q |-> clamp_q);
  assert_pwr_only_on_toggle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tog_i |=> $stable(pwr_en_q));
  assert_status_only_on_done_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_i |=> $stable(status_q));
endmodule

// File: rtl/pwr_part_gate_ctrl.sv
module pwr_part_gate_ctrl #(
  parameter int NP     = 32,
  parameter int SETTLE = 25,
  parameter int SWAP_A = 2,
  parameter int SWAP_B = 3,
  parameter int AW     = 8,
  parameter int DW     = 32,
  localparam int IDX_W = (NP > 1) ? $clog2(NP) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic [NP-1:0] pwr_en_o,
  output logic [NP-1:0] clamp_o,
  output logic          err_o
);
  logic             tog_ok, tog_drop, busy, done;
  logic [IDX_W-1:0] tog_idx, idx_q;
  logic [NP-1:0]    rel, status;
  logic             err_q;

  pgc_bus_decode #(.NP(NP), .AW(AW), .DW(DW), .SWAP_A(SWAP_A), .SWAP_B(SWAP_B)) u_dec (
    .req_i(req_i), .we_i(we_i), .addr_i(addr_i), .wdata_i(wdata_i),
    .busy_i(busy), .status_i(status),
    .tog_ok_o(tog_ok), .tog_drop_o(tog_drop), .tog_idx_o(tog_idx),
    .rel_o(rel), .rdata_o(rdata_o)
  );

  pgc_settle #(.SETTLE(SETTLE)) u_settle (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(tog_ok),
    .busy_o(busy), .done_o(done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= '0;
      err_q <= 1'b0;
    end else begin
      if (tog_ok)   idx_q <= tog_idx;
      if (tog_drop) err_q <= 1'b1;
    end
  end
  assign err_o = err_q;

  for (genvar i = 0; i < NP; i++) begin : g_part
    pgc_partition u_part (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .tog_i(tog_ok && (tog_idx == IDX_W'(i))),
      .done_i(done && (idx_q == IDX_W'(i))),
      .rel_i(rel[i]),
      .pwr_en_o(pwr_en_o[i]), .status_o(status[i]), .clamp_o(clamp_o[i])
    );
  end

  assert_err_sticky_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |=> err_q);
  assert_accept_or_drop_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({tog_ok, tog_drop}));
  assert_one_pwr_change_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(pwr_en_o ^ $past(pwr_en_o)) <= 1);
endmodule

// File: tb/pwr_part_gate_ctrl_test.sv
`timescale 1ns/1ps
module pwr_part_gate_ctrl_test;
  localparam int NP = 32;
  localparam int ST = 5;

  logic        clk = 0, rst_n = 0;
  logic        req = 0, we = 0;
  logic [7:0]  addr = 0;
  logic [31:0] wdata = 0;
  logic [31:0] rdata, pwr_en, clamp;
  logic        err;

  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  pwr_part_gate_ctrl #(.NP(NP), .SETTLE(ST)) uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .pwr_en_o(pwr_en), .clamp_o(clamp), .err_o(err)
  );

  // behavioural reference
  logic [31:0] m_pwr, m_stat, m_clamp;
  bit m_busy, m_err;
  int m_cnt, m_idx;

  function automatic int rel_bit(int n);
    if (n == 2) return 3;
    if (n == 3) return 2;
    return n;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pwr = 0; m_stat = 0; m_clamp = '1; m_busy = 0; m_err = 0; m_cnt = 0; m_idx = 0;
    end else begin
      bit was_busy;
      was_busy = m_busy;
      if (m_busy) begin
        if (m_cnt == 0) begin
          m_stat[m_idx] = m_pwr[m_idx];
          m_busy = 0;
        end else m_cnt--;
      end
      if (req && we && addr == 8'h30 && wdata[8]) begin
        if (was_busy) m_err = 1;
        else begin
          m_idx = int'(wdata[4:0]);
          m_pwr[m_idx] = ~m_pwr[m_idx];
          if (!m_pwr[m_idx]) m_clamp[m_idx] = 1;
          m_busy = 1; m_cnt = ST - 1;
        end
      end
      if (req && we && addr == 8'h34)
        for (int n = 0; n < NP; n++)
          if (wdata[rel_bit(n)] && m_pwr[n]) m_clamp[n] = 0;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // cycle compare
  always @(negedge clk) if (rst_n) begin
    chk("R2 pwr_en", pwr_en, m_pwr);
    chk("R5/R7 clamp", clamp, m_clamp);
    chk("R4 err", {31'b0, err}, {31'b0, m_err});
    chk("R3/R8 rdata", rdata, (req && !we && addr == 8'h38) ? m_stat : 32'h0);
  end

  task automatic idle_read;
    req = 1; we = 0; addr = 8'h38; wdata = 0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); #1;
    req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); #1;
    idle_read();
  endtask

  task automatic settle;
    repeat (ST + 2) @(negedge clk);
    #1;
  endtask

  task automatic finish_run;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R1 pwr_en reset", pwr_en, 32'h0);
    chk("R1 clamp reset", clamp, 32'hFFFF_FFFF);
    chk("R1 err reset", {31'b0, err}, 32'h0);
    rst_n = 1;
    idle_read();
    @(negedge clk); #1;
    chk("R1 status reset", rdata, 32'h0);

    wr(8'h30, 32'h0000_0004);                 // start bit clear
    chk("R2 no start ignored", pwr_en, 32'h0);

    wr(8'h30, 32'h0000_0104);                 // toggle p4, accepted at edge E
    chk("R2 toggle p4 on", pwr_en, 32'h10);
    chk("R3 status not yet", rdata, 32'h0);
    repeat (ST - 1) @(negedge clk);
    chk("R3 status edge before", rdata, 32'h0);
    @(negedge clk);
    chk("R3 status at SETTLE", rdata, 32'h10);
    settle();

    wr(8'h34, 32'h0000_0010);
    chk("R5 release p4", clamp[4], 32'h0);
    wr(8'h34, 32'h0000_0040);
    chk("R5 release unpowered p6 ignored", clamp[6], 32'h1);

    wr(8'h30, 32'h0000_0102); settle();       // power p2
    wr(8'h34, 32'h0000_0004);                 // bit 2 targets p3 (off)
    chk("R6 bit2 leaves p2 clamped", clamp[2], 32'h1);
    wr(8'h34, 32'h0000_0008);                 // bit 3 releases p2
    chk("R6 bit3 releases p2", clamp[2], 32'h0);
    chk("R6 p3 still clamped", clamp[3], 32'h1);
    wr(8'h30, 32'h0000_0103); settle();
    wr(8'h34, 32'h0000_0004);
    chk("R6 bit2 releases p3", clamp[3], 32'h0);

    wr(8'h30, 32'h0000_0104);                 // p4 off at edge E
    chk("R7 p4 re-clamped", clamp[4], 32'h1);
    chk("R7 p4 off", pwr_en[4], 32'h0);
    repeat (ST - 2) @(negedge clk);
    wr(8'h30, 32'h0000_0105);                 // lands on edge E+SETTLE
    chk("R4 boundary drop", pwr_en[5], 32'h0);
    chk("R4 err set", {31'b0, err}, 32'h1);
    wr(8'h30, 32'h0000_0106);                 // after completion
    chk("R4 accept after window", pwr_en[6], 32'h1);
    settle();

    @(negedge clk); #1; addr = 8'h30;
    @(negedge clk); chk("R8 read toggle ofs zero", rdata, 32'h0);
    #1 addr = 8'h34;
    @(negedge clk); chk("R8 read clamp ofs zero", rdata, 32'h0);
    #1 req = 0; addr = 8'h38;
    @(negedge clk); chk("R8 no request zero", rdata, 32'h0);
    #1 idle_read();

    wr(8'h38, 32'hFFFF_FFFF);
    wr(8'h3C, 32'hFFFF_FFFF);
    wr(8'h00, 32'hFFFF_FFFF);
    settle();
    chk("R9 pwr unchanged", pwr_en, 32'h4C);
    chk("R9 status unchanged", rdata, 32'h4C);
    chk("R4 err still set", {31'b0, err}, 32'h1);

    finish_run();
  end
endmodule